// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Port

This block holds the settings that a clock synthesizer's dividers read: a 9-bit feedback divide value, a 2-bit output divider select and a 2-bit test-output select. It has two ways to load them. The first is a set of parallel pins that can be hardwired on the board. The second is a three-wire serial port made of a serial clock, a data line and a load strobe. Both paths write into one register set. The parallel path is transparent while its strobe is low and latches on the strobe's rising edge. The serial path copies its shift register into the settings on a load edge. While the load strobe stays high, that copy passes the serial stream straight through to the settings.

All of the serial pins are slow, asynchronous controls. They are brought into the system clock through a synchronizer chain, and their edges are detected in that domain. A serial edge therefore takes effect on the third system clock edge after the pin changes. A test pin shows one of four sources, chosen by the test-select bits. Two of those sources, the feedback-divider output and the synthesized clock, arrive as plain input ports. The PLL itself is outside this block.

Top module: `clksyn_cfg_if`

## Requirements
- R1: While `rst_n` is low at a clock edge, `m_val` and `n_sel` load from `par_m` and `par_n`, `t_sel` becomes 00 and the shift register clears to all zeros.
- R2: While `par_load_n` is low, `m_val` and `n_sel` follow `par_m` and `par_n`, one clock after the pins change.
- R3: After `par_load_n` rises, changes on `par_m` and `par_n` are ignored: `m_val` and `n_sel` keep their values.
- R4: When `par_load_n` is high, each synchronized rising edge of `ser_clk` shifts `ser_data` into the 14-bit shift register at its least significant end. While `ser_load` is low, shifting leaves `m_val`, `n_sel` and `t_sel` unchanged.
- R5: A frame is shifted in first to last as follows: test select bit 1, test select bit 0, one spare bit, N bit 1, N bit 0, then M bit 8 down to M bit 0. The spare bit's value has no effect. Only a serial write changes `t_sel`.
- R6: A synchronized rising edge of `ser_load` copies the shift register fields into `m_val`, `n_sel` and `t_sel`. Once `ser_load` is low again, further shifting leaves those outputs unchanged.
- R7: While `ser_load` is held high, each shift also writes the new shift register fields into the outputs, so the outputs track the serial stream.
- R8: While `par_load_n` is high, `test_out` is selected by `t_sel`: 00 gives 0, 01 gives the shift register's oldest bit (the bit shifted in 14 shifts earlier), 10 gives `src_mdiv` and 11 gives `src_fout`.
- R9: While `par_load_n` is low, `test_out` is 0 whatever `t_sel` is.
- R10: `div_clear` follows `mr`. Asserting `mr` leaves `m_val`, `n_sel` and `t_sel` unchanged.
- R11: If a serial load edge arrives while `par_load_n` is low, the serial values win in that cycle, including `t_sel`. Parallel tracking resumes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| mr | input | 1 | Master divider reset request |
| par_load_n | input | 1 | Parallel strobe: low is transparent, the rising edge latches |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divider select |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe |
| src_mdiv | input | 1 | Feedback-divider output, a source for the test pin |
| src_fout | input | 1 | Synthesized clock, a source for the test pin |
| m_val | output | 9 | Feedback divide value |
| n_sel | output | 2 | Output divider select |
| t_sel | output | 2 | Test select bits |
| test_out | output | 1 | Test pin |
| div_clear | output | 1 | Divider clear sent to the dividers |

## Verification
The hardest case to reach from the ports is R11. A serial load edge has to land in a cycle where parallel mode is also active, and the serial value shows for only one cycle before parallel tracking overwrites it. The bench first shifts a frame while `par_load_n` is high, then drops `par_load_n` and lets the outputs settle on the pins. It then raises `ser_load` just after a falling edge, counts the synchronizer and edge-detect stages to the third rising edge, and samples in that one-cycle window. It samples once more a cycle later to confirm that parallel tracking has resumed.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int SPARE_W = 1;
  localparam int FRAME_W = T_W + SPARE_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SHIFT = 2'b01,
    TSEL_MDIV  = 2'b10,
    TSEL_FOUT  = 2'b11
  } tsel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_serial.sv
module cfg_serial
  import clk_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdat_s,
  input  logic               sload_s,
  input  logic               shift_en,
  output logic [FRAME_W-1:0] frame_nx,
  output logic               ser_wr,
  output logic               shift_out
);
  logic [FRAME_W-1:0] sr_q;
  logic sclk_d, sload_d;
  logic sclk_rise, load_rise, do_shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sload_d <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      sload_d <= sload_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign load_rise = sload_s & ~sload_d;
  assign do_shift  = sclk_rise & shift_en;

  always_comb begin
    frame_nx = sr_q;
    if (do_shift) frame_nx = {sr_q[FRAME_W-2:0], sdat_s};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= frame_nx;
  end

  // a load edge copies; a held-high strobe makes every shift a write
  assign ser_wr    = load_rise | (sload_s & do_shift);
  assign shift_out = sr_q[FRAME_W-1];
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import clk_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_load_n,
  input  logic [M_W-1:0]     par_m,
  input  logic [N_W-1:0]     par_n,
  input  logic [FRAME_W-1:0] frame_nx,
  input  logic               ser_wr,
  output cfg_t               cfg_q
);
  cfg_t ser_cfg;

  assign ser_cfg.t = frame_nx[FRAME_W-1 -: T_W];
  assign ser_cfg.n = frame_nx[M_W +: N_W];
  assign ser_cfg.m = frame_nx[M_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.m <= par_m;
      cfg_q.n <= par_n;
      cfg_q.t <= '0;
    end else if (ser_wr) begin
      cfg_q <= ser_cfg;
    end else if (!par_load_n) begin
      cfg_q.m <= par_m;
      cfg_q.n <= par_n;
    end
  end
endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import clk_cfg_pkg::*;
(
  input  logic           par_load_n,
  input  logic [T_W-1:0] t_sel,
  input  logic           shift_out,
  input  logic           src_mdiv,
  input  logic           src_fout,
  output logic           test_out
);
  always_comb begin
    test_out = 1'b0;
    if (par_load_n) begin
      unique case (tsel_e'(t_sel))
        TSEL_LOW:   test_out = 1'b0;
        TSEL_SHIFT: test_out = shift_out;
        TSEL_MDIV:  test_out = src_mdiv;
        TSEL_FOUT:  test_out = src_fout;
        default:    test_out = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/clksyn_cfg_if.sv
module clksyn_cfg_if
  import clk_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           src_mdiv,
  input  logic           src_fout,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_sel,
  output logic [T_W-1:0] t_sel,
  output logic           test_out,
  output logic           div_clear
);
  localparam int SW = 3;

  logic [SW-1:0]      pins_s;
  logic [FRAME_W-1:0] frame_nx;
  logic               ser_wr;
  logic               shift_out;
  cfg_t               cfg_q;

  cfg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_clk, ser_data, ser_load}), .q(pins_s)
  );

  cfg_serial u_serial (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .sdat_s(pins_s[1]), .sload_s(pins_s[0]),
    .shift_en(par_load_n),
    .frame_nx(frame_nx), .ser_wr(ser_wr), .shift_out(shift_out)
  );

  cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n),
    .par_m(par_m), .par_n(par_n),
    .frame_nx(frame_nx), .ser_wr(ser_wr), .cfg_q(cfg_q)
  );

  cfg_test_mux u_tmux (
    .par_load_n(par_load_n), .t_sel(cfg_q.t), .shift_out(shift_out),
    .src_mdiv(src_mdiv), .src_fout(src_fout), .test_out(test_out)
  );

  assign m_val     = cfg_q.m;
  assign n_sel     = cfg_q.n;
  assign t_sel     = cfg_q.t;
  assign div_clear = mr;
endmodule

// File: rtl/clksyn_cfg_if_chk.sv
module clksyn_cfg_if_chk
  import clk_cfg_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           par_load_n,
  input logic [M_W-1:0] par_m,
  input logic [N_W-1:0] par_n,
  input logic           ser_wr,
  input logic           src_mdiv,
  input logic [M_W-1:0] m_val,
  input logic [N_W-1:0] n_sel,
  input logic [T_W-1:0] t_sel,
  input logic           test_out
);
  AST_PAR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!par_load_n) && !$past(ser_wr) |->
      m_val == $past(par_m) && n_sel == $past(par_n)); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(par_load_n) && !$past(ser_wr) |->
      $stable(m_val) && $stable(n_sel)); // R3

  AST_TSEL_SERIAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(ser_wr) |-> $stable(t_sel)); // R5

  AST_TEST_MDIV: assert property (@(posedge clk) disable iff (!rst_n)
    par_load_n && t_sel == 2'b10 |-> test_out == src_mdiv); // R8

  AST_TEST_PAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load_n |-> !test_out); // R9
endmodule

bind clksyn_cfg_if clksyn_cfg_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n),
  .par_m(par_m), .par_n(par_n), .ser_wr(ser_wr), .src_mdiv(src_mdiv),
  .m_val(m_val), .n_sel(n_sel), .t_sel(t_sel), .test_out(test_out)
);

// File: tb/clksyn_cfg_if_bench.sv
module clksyn_cfg_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, mr = 1'b0, par_load_n = 1'b1;
  logic [8:0] par_m = 9'd300;
  logic [1:0] par_n = 2'd2;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic src_mdiv = 1'b0, src_fout = 1'b0;
  logic [8:0] m_val;
  logic [1:0] n_sel, t_sel;
  logic test_out, div_clear;

  int checks = 0, errors = 0;
  logic [13:0] model = '0;
  logic [8:0] exp_m;
  logic [1:0] exp_n, exp_t;
  bit done = 0;

  always #5 clk = ~clk;

  clksyn_cfg_if u_clksyn_cfg_if (
    .clk(clk), .rst_n(rst_n), .mr(mr), .par_load_n(par_load_n),
    .par_m(par_m), .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .src_mdiv(src_mdiv), .src_fout(src_fout),
    .m_val(m_val), .n_sel(n_sel), .t_sel(t_sel), .test_out(test_out),
    .div_clear(div_clear)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    ser_data = b; idle(4);
    ser_clk = 1'b1; idle(4);
    ser_clk = 1'b0; idle(4);
    if (par_load_n) model = {model[12:0], b};
  endtask

  task automatic send_frame(input logic [1:0] t, input logic sp,
                            input logic [1:0] n, input logic [8:0] m);
    logic [13:0] bits;
    bits = {t, sp, n, m};
    for (int i = 13; i >= 0; i--) ser_bit(bits[i]);
  endtask

  task automatic ser_pulse();
    ser_load = 1'b1; idle(4);
    ser_load = 1'b0; idle(4);
  endtask

  task automatic check_regs(input string tag);
    check({tag, " m"}, m_val, exp_m);
    check({tag, " n"}, n_sel, exp_n);
    check({tag, " t"}, t_sel, exp_t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1; idle(1);
    exp_m = 9'd300; exp_n = 2'd2; exp_t = 2'd0;
    check_regs("R1 reset");
    check("R1 test low after reset", test_out, 0);

    par_m = 9'd17; par_n = 2'd1; idle(3);
    check_regs("R3 pins ignored when latched");

    // R2 sweep of parallel transparency
    par_load_n = 1'b0;
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 4; k++) begin
        par_m = 9'((n * 131 + k * 47 + 3) % 512);
        par_n = 2'(n);
        idle(2);
        exp_m = par_m; exp_n = par_n;
        check_regs("R2 parallel track");
      end
    end
    par_load_n = 1'b1; idle(1);
    par_m = ~par_m; par_n = ~par_n; idle(3);
    check_regs("R3 latched after rise");

    // R4/R5/R6/R8 sweep over all test selects and divider selects
    for (int t = 0; t < 4; t++) begin
      for (int n = 0; n < 4; n++) begin
        logic [8:0] m;
        m = 9'((t * 97 + n * 61 + 29) % 512);
        send_frame(2'(t), 1'((t + n) & 1), 2'(n), m);
        check_regs("R4 shift without load");
        ser_pulse();
        exp_m = m; exp_n = 2'(n); exp_t = 2'(t);
        check_regs("R5 frame fields");
        for (int s = 0; s < 4; s++) begin
          int e;
          src_mdiv = s[0]; src_fout = s[1]; idle(1);
          case (t)
            0: e = 0;
            1: e = model[13];
            2: e = s[0];
            default: e = s[1];
          endcase
          check("R8 test select", test_out, e);
        end
      end
    end

    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
    check_regs("R6 held after load fall");

    // R7 transparent stream
    ser_load = 1'b1; idle(4);
    for (int i = 0; i < 14; i++) begin
      ser_bit(1'((i * 5 + 1) % 3 == 0));
      exp_t = model[13:12]; exp_n = model[10:9]; exp_m = model[8:0];
      check_regs("R7 transparent");
    end
    ser_load = 1'b0; idle(4);
    ser_bit(1'b0); ser_bit(1'b1);
    check_regs("R6 held after transparent");

    // R10 master reset
    mr = 1'b1; idle(2);
    check("R10 div_clear high", div_clear, 1);
    ser_bit(1'b1);
    check_regs("R10 regs kept under mr");
    mr = 1'b0; idle(1);
    check("R10 div_clear low", div_clear, 0);

    // R9 parallel forces test low
    send_frame(2'd2, 1'b0, 2'd1, 9'd77); ser_pulse();
    src_mdiv = 1'b1; idle(1);
    check("R8 mdiv routed", test_out, 1);
    par_load_n = 1'b0; par_m = 9'd77; par_n = 2'd1; idle(1);
    check("R9 test low in parallel", test_out, 0);

    // R11 collision of parallel mode and serial load
    par_load_n = 1'b1; idle(1);
    send_frame(2'd1, 1'b1, 2'd3, 9'd5);
    par_load_n = 1'b0; par_m = 9'd400; par_n = 2'd0; idle(2);
    exp_m = 9'd400; exp_n = 2'd0; exp_t = 2'd2;
    check_regs("R11 parallel before collision");
    ser_load = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_m = 9'd5; exp_n = 2'd3; exp_t = 2'd1;
    check_regs("R11 serial wins");
    @(posedge clk); #1;
    exp_m = 9'd400; exp_n = 2'd0;
    check_regs("R11 parallel resumes");
    ser_load = 1'b0; idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule